// File: doc/BRIEF.md
# Source-Routed Wormhole Switch Port

This block is one input of a small packet switch with four outputs. It routes packets by source routing and moves them by wormhole flow control. The sender writes the whole route into the first flit: one output selector for each switch on the path, with the selector for the nearest switch in the most significant position. The block reads the leading selector and sends the head flit to that output. It removes the selector by shifting the head payload left, so the next switch finds its own selector at the top. The block has no routing table.

The head is forwarded in the same cycle it arrives. The block then locks the chosen output for the body and tail flits of that packet. The lock ends when the tail flit is accepted downstream. The block holds no flit storage. A blocked output stalls the worm in place through the valid/ready handshake, and no part of the packet is gathered locally. A packet of one flit (head-tail) is routed and stripped like a head but sets no lock. The next packet can take a different output in the cycle right after a tail.

The control is a two-state machine. `ST_IDLE` waits for a head and routes it by its selector. `ST_WORM` forwards flits unchanged on the locked output. Its transitions are:

- **open**: `ST_IDLE` to `ST_WORM`, taken when a head flit is accepted.
- **close**: `ST_WORM` to `ST_IDLE`, taken when a tail flit is accepted.
- **single**: `ST_IDLE` to `ST_IDLE`, taken when a head-tail flit is accepted.
- **hold**: the machine stays in its state in every other cycle.

Top module: `wormhole_switch_port`

## Requirements
- R1: A flit is `{kind[1:0], payload[DATA_W-1:0]}`. The kind codes are 00 body, 01 head, 10 tail and 11 head-tail. The output selector of a head or head-tail flit is `payload[DATA_W-1 -: 2]`.
- R2: In `ST_IDLE`, a valid head or head-tail flit raises `out_valid` only on the output its selector names. `out_valid` is never asserted on more than one output.
- R3: A head or head-tail flit leaves with its kind unchanged. Its payload is shifted left by 2 bits, with zeros filling the two low bits.
- R4: After a head flit is accepted, every later flit goes to the same output with its flit unchanged, whatever its payload holds. This lasts until a tail flit is accepted.
- R5: `in_ready` equals the `out_ready` of the locked output during a worm. In `ST_IDLE` with a head or head-tail flit, it equals the `out_ready` of the selected output. The `out_ready` of any other output has no effect.
- R6: While the target output is not ready, the flit stays on that output and nothing is accepted. The block stores no flit, and a head that is not accepted creates no lock.
- R7: In the cycle after a tail is accepted, a new head is routed to any output, with no idle cycle in between.
- R8: A head-tail flit is routed and stripped like a head. It leaves the block in `ST_IDLE`, so the next head picks its own output.
- R9: A body or tail flit that arrives in `ST_IDLE` is discarded. `in_ready` is 1 and no `out_valid` rises.
- R10: After reset the block is in `ST_IDLE` and all `out_valid` bits are 0.
- R11: `out_valid` never rises without `in_valid`. All four `out_flit` lanes carry the same forwarded flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input flit is valid |
| in_flit | input | DATA_W+2 | Input flit: kind and payload |
| in_ready | output | 1 | Input flit is accepted in this cycle |
| out_valid | output | PORTS | Per-output valid |
| out_flit | output | PORTS*(DATA_W+2) | Per-output flit lanes; lane p is bits [p*(DATA_W+2) +: DATA_W+2] |
| out_ready | input | PORTS | Per-output ready from downstream |

## Verification
The assertions assume a well-behaved sender. Once a flit is presented and not accepted, the sender keeps `in_valid` high and `in_flit` stable until the flit is accepted. Each packet also starts with a head and ends with a tail. The stall check on the outputs depends on the first of these assumptions. The directed bench therefore presents a blocked flit again unchanged until it is accepted. It closes every worm with a tail, and it sends stray body and tail flits only while no worm is open.

// File: rtl/whsw_pkg.sv
package whsw_pkg;
    localparam int KIND_W = 2;

    typedef enum logic [KIND_W-1:0] {
        FT_BODY = 2'b00,
        FT_HEAD = 2'b01,
        FT_TAIL = 2'b10,
        FT_SOLO = 2'b11
    } flit_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WORM = 1'b1
    } path_state_e;
endpackage

// File: rtl/whsw_head_strip.sv
module whsw_head_strip #(
    parameter int DATA_W = 16,
    parameter int SEL_W  = 2
) (
    input  logic [DATA_W-1:0] payload_i,
    output logic [SEL_W-1:0]  sel_o,
    output logic [DATA_W-1:0] stripped_o
);
    // The leading selector sits at the top of the payload.
    assign sel_o      = payload_i[DATA_W-1 -: SEL_W];
    // Drop the used selector and move the rest of the route up.
    assign stripped_o = {payload_i[DATA_W-SEL_W-1:0], {SEL_W{1'b0}}};
endmodule

// File: rtl/whsw_path_fsm.sv
module whsw_path_fsm
    import whsw_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid_i,
    input  logic             in_ready_i,
    input  flit_kind_e       kind_i,
    input  logic [SEL_W-1:0] head_sel_i,
    output logic             route_en_o,
    output logic [SEL_W-1:0] route_sel_o,
    output logic             strip_o,
    output logic             worm_o
);
    path_state_e      state_q, state_d;
    logic [SEL_W-1:0] lock_q, lock_d;
    logic             fire;

    assign fire = in_valid_i && in_ready_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lock_q  <= '0;
        end else begin
            state_q <= state_d;
            lock_q  <= lock_d;
        end
    end

    // Transitions: open, close, single, hold
    always_comb begin
        state_d = state_q;
        lock_d  = lock_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fire && kind_i == FT_HEAD) begin
                    state_d = ST_WORM;
                    lock_d  = head_sel_i;
                end
            end
            ST_WORM: begin
                if (fire && kind_i == FT_TAIL) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        route_en_o  = 1'b0;
        route_sel_o = head_sel_i;
        strip_o     = 1'b0;
        worm_o      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                route_en_o  = (kind_i == FT_HEAD) || (kind_i == FT_SOLO);
                route_sel_o = head_sel_i;
                strip_o     = 1'b1;
            end
            ST_WORM: begin
                route_en_o  = 1'b1;
                route_sel_o = lock_q;
                worm_o      = 1'b1;
            end
            default: ;
        endcase
    end

    // R4
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WORM && !(fire && kind_i == FT_TAIL))
        |=> (state_q == ST_WORM && lock_q == $past(lock_q)));

    // R8
    solo_nolock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && fire && kind_i == FT_SOLO) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/whsw_out_demux.sv
module whsw_out_demux #(
    parameter int PORTS  = 4,
    parameter int FLIT_W = 18,
    parameter int SEL_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid_i,
    input  logic                    en_i,
    input  logic [SEL_W-1:0]        sel_i,
    input  logic [FLIT_W-1:0]       flit_i,
    input  logic [PORTS-1:0]        out_ready_i,
    output logic [PORTS-1:0]        out_valid_o,
    output logic [PORTS*FLIT_W-1:0] out_flit_o,
    output logic                    sel_ready_o
);
    for (genvar g = 0; g < PORTS; g++) begin : g_lane
        assign out_valid_o[g] = valid_i && en_i && (sel_i == SEL_W'(g));
        assign out_flit_o[g*FLIT_W +: FLIT_W] = flit_i;
    end

    assign sel_ready_o = out_ready_i[sel_i];

    // R2
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_valid_o));
endmodule

// File: rtl/wormhole_switch_port.sv
module wormhole_switch_port
    import whsw_pkg::*;
#(
    parameter int  PORTS  = 4,
    parameter int  DATA_W = 16,
    localparam int SEL_W  = $clog2(PORTS),
    localparam int FLIT_W = DATA_W + KIND_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [FLIT_W-1:0]       in_flit,
    output logic                    in_ready,
    output logic [PORTS-1:0]        out_valid,
    output logic [PORTS*FLIT_W-1:0] out_flit,
    input  logic [PORTS-1:0]        out_ready
);
    flit_kind_e        kind;
    logic [DATA_W-1:0] payload;
    logic [DATA_W-1:0] stripped;
    logic [SEL_W-1:0]  head_sel;
    logic [SEL_W-1:0]  route_sel;
    logic              route_en;
    logic              strip;
    logic              worm;
    logic              sel_ready;
    logic [FLIT_W-1:0] fwd_flit;

    assign kind    = flit_kind_e'(in_flit[FLIT_W-1 -: KIND_W]);
    assign payload = in_flit[DATA_W-1:0];

    whsw_head_strip #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_strip (
        .payload_i  (payload),
        .sel_o      (head_sel),
        .stripped_o (stripped)
    );

    whsw_path_fsm #(.SEL_W(SEL_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (in_valid),
        .in_ready_i  (in_ready),
        .kind_i      (kind),
        .head_sel_i  (head_sel),
        .route_en_o  (route_en),
        .route_sel_o (route_sel),
        .strip_o     (strip),
        .worm_o      (worm)
    );

    assign fwd_flit = strip ? {kind, stripped} : in_flit;

    whsw_out_demux #(.PORTS(PORTS), .FLIT_W(FLIT_W), .SEL_W(SEL_W)) u_demux (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (in_valid),
        .en_i        (route_en),
        .sel_i       (route_sel),
        .flit_i      (fwd_flit),
        .out_ready_i (out_ready),
        .out_valid_o (out_valid),
        .out_flit_o  (out_flit),
        .sel_ready_o (sel_ready)
    );

    // Flits with no target in ST_IDLE are discarded.
    assign in_ready = route_en ? sel_ready : 1'b1;

    // R11
    no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_valid) |-> in_valid);

    // R5
    ready_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(out_valid & out_ready)) |-> in_ready);

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(out_valid & ~out_ready)) |=> ($stable(out_valid) && $stable(out_flit)));

    // R3
    strip_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|out_valid) && !worm) |-> (out_flit[SEL_W-1:0] == '0));
endmodule

// File: tb/wormhole_switch_port_bench.sv
module wormhole_switch_port_bench;
    localparam int PORTS  = 4;
    localparam int DATA_W = 16;
    localparam int FLIT_W = DATA_W + 2;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic [FLIT_W-1:0]       in_flit = '0;
    logic                    in_ready;
    logic [PORTS-1:0]        out_valid;
    logic [PORTS*FLIT_W-1:0] out_flit;
    logic [PORTS-1:0]        out_ready = '0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    wormhole_switch_port #(.PORTS(PORTS), .DATA_W(DATA_W)) u_wormhole_switch_port (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
        .in_ready(in_ready), .out_valid(out_valid), .out_flit(out_flit),
        .out_ready(out_ready)
    );

    function automatic logic [FLIT_W-1:0] mk(input logic [1:0] k, input logic [15:0] p);
        return {k, p};
    endfunction

    function automatic logic [FLIT_W-1:0] lane(input int p);
        return out_flit[p*FLIT_W +: FLIT_W];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive after a falling edge and settle before sampling.
    task automatic apply(input logic v, input logic [FLIT_W-1:0] f, input logic [3:0] rdy);
        @(negedge clk);
        in_valid  = v;
        in_flit   = f;
        out_ready = rdy;
        #1;
    endtask

    task automatic t_reset();
        check("R10 out_valid after reset", 32'(out_valid), 32'h0);
    endtask

    task automatic t_head_route();
        apply(1'b1, mk(2'b01, 16'hB5A3), 4'b1111);
        check("R2 head to port 2", 32'(out_valid), 32'h4);
        check("R3 R1 stripped head on lane 2", 32'(lane(2)), 32'(mk(2'b01, 16'hD68C)));
        check("R5 in_ready head", 32'(in_ready), 32'h1);
    endtask

    task automatic t_body_follow();
        apply(1'b1, mk(2'b00, 16'hC000), 4'b1111);
        check("R4 body stays on port 2", 32'(out_valid), 32'h4);
        check("R4 body unchanged", 32'(lane(2)), 32'(mk(2'b00, 16'hC000)));
    endtask

    task automatic t_stall();
        apply(1'b1, mk(2'b00, 16'h1111), 4'b1011);
        check("R5 in_ready low when locked port blocked", 32'(in_ready), 32'h0);
        check("R6 body held on port 2", 32'(out_valid), 32'h4);
        apply(1'b1, mk(2'b00, 16'h1111), 4'b0100);
        check("R6 still on port 2 after stall", 32'(out_valid), 32'h4);
        check("R5 other ports ignored", 32'(in_ready), 32'h1);
    endtask

    task automatic t_tail_switch();
        apply(1'b1, mk(2'b10, 16'h2222), 4'b1111);
        check("R4 tail on port 2", 32'(out_valid), 32'h4);
        check("R4 tail unchanged", 32'(lane(2)), 32'(mk(2'b10, 16'h2222)));
        apply(1'b1, mk(2'b01, 16'h4321), 4'b1111);
        check("R7 next head to port 1 at once", 32'(out_valid), 32'h2);
        check("R7 R3 stripped head lane 1", 32'(lane(1)), 32'(mk(2'b01, 16'h0C84)));
        apply(1'b1, mk(2'b10, 16'h0000), 4'b1111);
        check("R4 close worm on port 1", 32'(out_valid), 32'h2);
    endtask

    task automatic t_solo_block();
        apply(1'b1, mk(2'b11, 16'hFFFF), 4'b1111);
        check("R8 head-tail to port 3", 32'(out_valid), 32'h8);
        check("R8 head-tail stripped", 32'(lane(3)), 32'(mk(2'b11, 16'hFFFC)));
        apply(1'b1, mk(2'b01, 16'h1234), 4'b1110);
        check("R8 no lock after head-tail", 32'(out_valid), 32'h1);
        check("R6 blocked head in_ready", 32'(in_ready), 32'h0);
        apply(1'b1, mk(2'b01, 16'h1234), 4'b1111);
        check("R6 blocked head still on port 0", 32'(out_valid), 32'h1);
        check("R3 stripped head lane 0", 32'(lane(0)), 32'(mk(2'b01, 16'h48D0)));
        apply(1'b1, mk(2'b10, 16'h5555), 4'b1111);
        check("R4 tail on port 0", 32'(out_valid), 32'h1);
    endtask

    task automatic t_stray();
        apply(1'b1, mk(2'b00, 16'hAAAA), 4'b0000);
        check("R9 stray body no output", 32'(out_valid), 32'h0);
        check("R9 stray body accepted", 32'(in_ready), 32'h1);
        apply(1'b1, mk(2'b10, 16'hBBBB), 4'b0000);
        check("R9 stray tail no output", 32'(out_valid), 32'h0);
        apply(1'b1, mk(2'b01, 16'h4321), 4'b1111);
        check("R9 no lock from stray flits", 32'(out_valid), 32'h2);
        check("R11 same flit on all lanes", 32'(lane(3)), 32'(lane(1)));
        apply(1'b1, mk(2'b10, 16'h0001), 4'b1111);
        check("R4 close", 32'(out_valid), 32'h2);
        apply(1'b0, mk(2'b01, 16'h4321), 4'b1111);
        check("R11 no valid without in_valid", 32'(out_valid), 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_head_route();
        t_body_follow();
        t_stall();
        t_tail_switch();
        t_solo_block();
        t_stray();
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule